// File: doc/BRIEF.md
# Timer Capture/Compare Status Flags

This block keeps the interrupt status bits of a four-channel general-purpose timer. Single-cycle event strobes from the timer core (compare hits, capture events, counter wrap, software update request and slave restart trigger) set sticky flags. Software clears them through a one-register write port, writing ones to the bits it wants cleared. A channel in input mode also clears its capture/compare flag when its capture register is read.

Each channel has a capture/compare flag and an over-capture flag. The over-capture flag records a capture that arrived while the previous one was still pending. A single update flag covers the whole timer. A masked OR of all flags forms one interrupt request. The counter, the comparators, the capture registers and the input filters sit outside this block. It only sees their strobes.

Top module: `tmr_flag_bank`

## Requirements
- R1: After reset `status` is all zero and `irq` is low.
- R2: `status` layout: bit 8 is the update flag, bits 7..4 are the over-capture flags of channels 3..0, and bits 3..0 are the capture/compare flags of channels 3..0. Any one of `cnt_wrap`, `sw_upd` or `slv_restart` sets bit 8 on the next clock.
- R3: A channel whose `ch_is_in` bit is 0 (output mode) sets its capture/compare flag on the clock after its `cmp_hit` strobe, provided `center_mode` is 0.
- R4: While `center_mode` is 1, `cmp_hit` does not set any capture/compare flag.
- R5: A channel whose `ch_is_in` bit is 1 (input mode) sets its capture/compare flag on `cap_hit`. In input mode `cmp_hit` has no effect. In output mode `cap_hit` has no effect.
- R6: In input mode, a `cap_hit` that arrives while the channel's capture/compare flag is already set sets that channel's over-capture flag.
- R7: In input mode, `cap_rd` clears the channel's capture/compare flag. In output mode `cap_rd` has no effect.
- R8: A cycle with `wr_en` high clears every status bit whose `wr_data` bit is 1. Bits written with 0 keep their value.
- R9: When a hardware set and a clear reach the same bit in the same cycle, the bit ends up set.
- R10: The update and over-capture flags are cleared only by the write port. `cap_rd` leaves them unchanged.
- R11: `irq` is high exactly when some bit of `status & irq_mask` is 1.
- R12: A `cap_hit` and a `cap_rd` in the same cycle on an input channel whose flag is set leave both its capture/compare flag and its over-capture flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hit | input | 4 | Per-channel compare match strobe |
| cap_hit | input | 4 | Per-channel capture event strobe |
| ch_is_in | input | 4 | Per-channel mode: 1 input, 0 output |
| center_mode | input | 1 | Counter runs center-aligned |
| cnt_wrap | input | 1 | Counter overflow/underflow strobe |
| sw_upd | input | 1 | Software update request strobe |
| slv_restart | input | 1 | Slave restart trigger strobe |
| cap_rd | input | 4 | Per-channel capture register read strobe |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 9 | Write-one-to-clear data |
| irq_mask | input | 9 | Interrupt enable per status bit |
| status | output | 9 | Status flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that an update source sets bit 8 and that a compare match sets its channel's flag in output mode. They also check that center-aligned mode blocks compare matches, that a repeated capture raises over-capture, that over-capture flags stay set without a write, that a lone clear empties a bit and that a set wins over a clear. The bench scenarios cover the rest. They show that mode-dependent strobes are ignored, that `cap_rd` leaves the update and over-capture bits alone, and that the interrupt mask behaves as required. They also cover a capture and a read landing in the same cycle. A long pseudo-random sweep then compares every cycle against a model built from the requirements.

// File: rtl/tmr_flag_bank.sv
`timescale 1ns/1ps
module tmr_flag_bank #(
  parameter int NCH = 4,
  localparam int SW = 2*NCH + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cmp_hit,
  input  logic [NCH-1:0] cap_hit,
  input  logic [NCH-1:0] ch_is_in,
  input  logic           center_mode,
  input  logic           cnt_wrap,
  input  logic           sw_upd,
  input  logic           slv_restart,
  input  logic [NCH-1:0] cap_rd,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_data,
  input  logic [SW-1:0]  irq_mask,
  output logic [SW-1:0]  status,
  output logic           irq
);
  localparam int UPD = 2*NCH;

  logic [NCH-1:0] cc_q, ov_q;
  logic           upd_q;
  logic [SW-1:0]  wclr;

  assign wclr = wr_en ? wr_data : '0;

  wire [NCH-1:0] cc_set = (ch_is_in & cap_hit) | (~ch_is_in & cmp_hit & {NCH{~center_mode}});
  wire [NCH-1:0] cc_clr = wclr[NCH-1:0] | (ch_is_in & cap_rd);
  wire [NCH-1:0] ov_set = ch_is_in & cap_hit & cc_q;
  wire           up_set = cnt_wrap | sw_upd | slv_restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q  <= '0;
      ov_q  <= '0;
      upd_q <= 1'b0;
    end else begin
      cc_q  <= cc_set | (cc_q & ~cc_clr);
      ov_q  <= ov_set | (ov_q & ~wclr[2*NCH-1:NCH]);
      upd_q <= up_set | (upd_q & ~wclr[UPD]);
    end
  end

  assign status = {upd_q, ov_q, cc_q};
  assign irq    = |(status & irq_mask);
endmodule

module tmr_flag_bank_chk #(
  parameter int NCH = 4,
  localparam int SW = 2*NCH + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] cmp_hit,
  input logic [NCH-1:0] cap_hit,
  input logic [NCH-1:0] ch_is_in,
  input logic           center_mode,
  input logic           cnt_wrap,
  input logic           sw_upd,
  input logic           slv_restart,
  input logic [NCH-1:0] cap_rd,
  input logic           wr_en,
  input logic [SW-1:0]  wr_data,
  input logic [SW-1:0]  status
);
  assert_upd_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wrap || sw_upd || slv_restart) |=> status[2*NCH]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_cmp_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_is_in[i] && !center_mode && cmp_hit[i]) |=> status[i]);
    assert_center_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_is_in[i] && center_mode && !status[i]) |=> !status[i]);
    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_is_in[i] && cap_hit[i] && status[i]) |=> status[NCH+i]);
    assert_ovf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status[NCH+i] && !(wr_en && wr_data[NCH+i])) |=> status[NCH+i]);
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[i] && !(ch_is_in[i] ? cap_hit[i] : (cmp_hit[i] && !center_mode))) |=> !status[i]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_is_in[i] && cap_hit[i] && wr_en && wr_data[i]) |=> status[i]);
  end
endmodule

bind tmr_flag_bank tmr_flag_bank_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmp_hit(cmp_hit), .cap_hit(cap_hit),
  .ch_is_in(ch_is_in), .center_mode(center_mode), .cnt_wrap(cnt_wrap),
  .sw_upd(sw_upd), .slv_restart(slv_restart), .cap_rd(cap_rd),
  .wr_en(wr_en), .wr_data(wr_data), .status(status)
);

// File: tb/tmr_flag_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_flag_bank_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0] cmp_hit, cap_hit, ch_is_in, cap_rd;
  logic center_mode, cnt_wrap, sw_upd, slv_restart, wr_en;
  logic [8:0] wr_data, irq_mask, status, exp_s;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_flag_bank dut_i (.clk(clk), .rst_n(rst_n), .cmp_hit(cmp_hit), .cap_hit(cap_hit),
    .ch_is_in(ch_is_in), .center_mode(center_mode), .cnt_wrap(cnt_wrap), .sw_upd(sw_upd),
    .slv_restart(slv_restart), .cap_rd(cap_rd), .wr_en(wr_en), .wr_data(wr_data),
    .irq_mask(irq_mask), .status(status), .irq(irq));

  function automatic logic [8:0] model(logic [8:0] s);
    logic [8:0] n;
    logic [8:0] w = wr_en ? wr_data : 9'h0;
    for (int i = 0; i < 4; i++) begin
      logic setc = ch_is_in[i] ? cap_hit[i] : (cmp_hit[i] & ~center_mode);
      logic clrc = w[i] | (ch_is_in[i] & cap_rd[i]);
      n[i]   = setc | (s[i] & ~clrc);
      n[4+i] = (ch_is_in[i] & cap_hit[i] & s[i]) | (s[4+i] & ~w[4+i]);
    end
    n[8] = (cnt_wrap | sw_upd | slv_restart) | (s[8] & ~w[8]);
    return n;
  endfunction

  task automatic chk(string tag, logic [8:0] exp);
    checks++;
    if (status !== exp) begin
      fails++;
      $display("FAIL %s status=%h expected=%h", tag, status, exp);
    end
    checks++;
    if (irq !== |(exp & irq_mask)) begin
      fails++;
      $display("FAIL R11 (%s) irq=%b expected=%b", tag, irq, |(exp & irq_mask));
    end
  endtask

  task automatic idle();
    cmp_hit = 0; cap_hit = 0; cap_rd = 0; cnt_wrap = 0; sw_upd = 0;
    slv_restart = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic step(string tag);
    logic [8:0] nx = model(exp_s);
    @(posedge clk); #1;
    exp_s = nx;
    chk(tag, exp_s);
    idle();
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 9'h1FF; step("R8 clear all");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(); ch_is_in = 0; center_mode = 0; irq_mask = 9'h1FF; exp_s = 0;
    #45; chk("R1 reset", 9'h0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after release", 9'h0);

    cnt_wrap = 1; step("R2 wrap");
    clear_all();
    sw_upd = 1; step("R2 sw update");
    wr_en = 1; wr_data = 9'h0FF; step("R8 write zero keeps update");
    clear_all();
    slv_restart = 1; step("R2 restart");
    clear_all();

    for (int c = 0; c < 4; c++) begin
      ch_is_in = 0; center_mode = 0;
      cmp_hit[c] = 1; step("R3 compare sets");
      cap_hit[c] = 1; step("R5 capture ignored in output mode");
      cap_rd[c] = 1; step("R7 read ignored in output mode");
      clear_all();
      center_mode = 1; cmp_hit = 4'hF; step("R4 center mode blocks");
      center_mode = 0;
      ch_is_in[c] = 1;
      cmp_hit[c] = 1; step("R5 compare ignored in input mode");
      cap_hit[c] = 1; step("R5 capture sets");
      cap_hit[c] = 1; step("R6 over-capture");
      cap_rd[c] = 1; step("R7 read clears flag");
      cap_rd = 4'hF; step("R10 read keeps over-capture");
      cap_hit[c] = 1; wr_en = 1; wr_data[c] = 1; step("R9 set beats clear");
      cap_hit[c] = 1; cap_rd[c] = 1; step("R12 capture with read");
      clear_all();
    end

    ch_is_in = 4'hF; cap_hit = 4'hF; cnt_wrap = 1; step("R11 fill");
    cap_hit = 4'hF; step("R11 fill ov");
    for (int b = 0; b < 9; b++) begin
      irq_mask = 9'h1 << b; step("R11 mask single bit");
    end
    irq_mask = 0; step("R11 mask off");
    wr_en = 1; wr_data = 9'h0AA; irq_mask = 9'h0AA; step("R8 partial clear");
    irq_mask = 9'h1FF;
    clear_all();

    begin
      logic [31:0] r = 32'h1ACE_B00C;
      for (int n = 0; n < 6000; n++) begin
        r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
        cmp_hit = r[3:0] & r[7:4];
        cap_hit = r[11:8] & r[15:12];
        cap_rd  = r[19:16] & r[23:20];
        if (r[30:28] == 0) ch_is_in = r[27:24];
        center_mode = (r[31:29] == 0) ? ~center_mode : center_mode;
        cnt_wrap = r[0] & r[9] & r[18];
        sw_upd = r[1] & r[10] & r[19] & r[28];
        slv_restart = r[2] & r[11] & r[20] & r[29];
        wr_en = r[3] & r[12];
        wr_data = r[24:16] ^ r[8:0];
        irq_mask = r[31:23];
        step("R3/R5/R6/R7/R8/R9/R12 sweep");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule